// File: doc/BRIEF.md
# Clip Flag Generator with Minimum-Width Stretch

This block watches two channels of sampled error-amplifier codes and tells the rest of the chip when either channel has left its linear range. Each clock, every channel code is compared against a window centred on mid-scale. The lower bound sits at one tenth of full scale and the upper bound at nine tenths. A code outside the window raises that channel's active-low clip flag.

A flag that has been raised is held low for a minimum time, 1 µs by default, so that a single out-of-range sample still gives a pulse wide enough to see. Another out-of-range sample during the hold restarts the hold from that sample. The two channels are fully independent. A shared shutdown status forces both flags inactive at once and throws away any hold in progress. Codes sampled while shutdown is high are ignored.

Top module: `clip_flag_gen`

## Requirements
- R1: With CODE_W = 12 the lower limit is 409, which is full scale 4095 times 10 / 100 rounded down. A code below 409 counts as out of window; the code 409 itself does not.
- R2: With CODE_W = 12 the upper limit is 3685, which is 4095 times 90 / 100 rounded down. A code above 3685 counts as out of window; the code 3685 itself does not.
- R3: The flags are active low (0 = clipping). An out-of-window code present at a rising clock edge, with shutdown low, drives that channel's flag to 0 straight after that edge.
- R4: Once raised, a flag stays at 0 for exactly HOLD_CYC clock cycles after the last out-of-window sample, then returns to 1. HOLD_CYC = CLK_KHZ * HOLD_NS / 1,000,000, which is 200 cycles for the defaults of 200 MHz and 1000 ns.
- R5: An out-of-window sample taken while a flag is already being held restarts the full HOLD_CYC count from that sample.
- R6: Each channel's flag depends only on that channel's codes and on the shared shutdown input.
- R7: While shutdown is 1, both flags read 1 at once, without waiting for a clock edge. Shutdown also clears any hold in progress, and codes sampled during shutdown are ignored. After shutdown falls, a flag stays at 1 until a new out-of-window sample arrives.
- R8: While synchronous reset is asserted, and after it is released, both flags read 1 until an out-of-window sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch0_code | input | CODE_W | Sampled error-amplifier code, channel 0 |
| ch1_code | input | CODE_W | Sampled error-amplifier code, channel 1 |
| shdn | input | 1 | Shutdown status, active high |
| clip0_n | output | 1 | Clip flag, channel 0, active low |
| clip1_n | output | 1 | Clip flag, channel 1, active low |

## Verification
The bench keeps CODE_W at 12, so both window limits are exercised with codes on and just past each limit. It sets HOLD_NS to 60 at a 200 MHz clock, which gives a hold of 12 cycles. With a hold that short, the bench can watch natural release, restart in the middle of a hold, and a shutdown that cuts a hold short, many times within a short run. A reference model of remaining hold time per channel is compared against both flags on every cycle.

// File: rtl/clip_pkg.sv
package clip_pkg;
   // floor of (2^w - 1) * pct / 100
   function automatic int unsigned scale_limit(input int unsigned w, input int unsigned pct);
      longint unsigned full;
      full = (64'd1 << w) - 64'd1;
      return int'((full * pct) / 100);
   endfunction
endpackage

// File: rtl/clip_window_cmp.sv
module clip_window_cmp #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned LO_PCT = 10,
   parameter int unsigned HI_PCT = 90
) (
   input  logic [CODE_W-1:0] code,
   output logic              outside
);
   import clip_pkg::*;
   localparam int unsigned LO_LIM = scale_limit(CODE_W, LO_PCT);
   localparam int unsigned HI_LIM = scale_limit(CODE_W, HI_PCT);
   localparam logic [CODE_W-1:0] LO_C = CODE_W'(LO_LIM);
   localparam logic [CODE_W-1:0] HI_C = CODE_W'(HI_LIM);

   if (LO_PCT >= HI_PCT) begin : g_bad_pct
      $error("clip_window_cmp: LO_PCT must be below HI_PCT");
   end

   always_comb outside = (code < LO_C) || (code > HI_C);
endmodule

// File: rtl/clip_stretch.sv
module clip_stretch #(
   parameter int unsigned HOLD_CYC = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic trig,
   output logic busy
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst || clr)
         remain_q <= '0;
      else if (trig)
         remain_q <= LOAD;
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   always_comb busy = (remain_q != '0);
endmodule

// File: rtl/clip_flag_gen.sv
module clip_flag_gen #(
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned CLK_KHZ = 200000,
   parameter int unsigned HOLD_NS = 1000,
   parameter int unsigned LO_PCT  = 10,
   parameter int unsigned HI_PCT  = 90
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] ch0_code,
   input  logic [CODE_W-1:0] ch1_code,
   input  logic              shdn,
   output logic              clip0_n,
   output logic              clip1_n
);
   localparam int unsigned NCH      = 2;
   localparam int unsigned HOLD_CYC = int'((64'(CLK_KHZ) * 64'(HOLD_NS)) / 64'd1000000);

   if (CODE_W < 4 || CODE_W > 24) begin : g_bad_w
      $error("clip_flag_gen: CODE_W out of range 4..24");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("clip_flag_gen: hold time shorter than one clock");
   end

   logic [CODE_W-1:0] code_a [NCH];
   logic [NCH-1:0]    outside;
   logic [NCH-1:0]    busy;
   logic [NCH-1:0]    flag_n;

   always_comb begin
      code_a[0] = ch0_code;
      code_a[1] = ch1_code;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      clip_window_cmp #(
         .CODE_W (CODE_W),
         .LO_PCT (LO_PCT),
         .HI_PCT (HI_PCT)
      ) u_cmp (
         .code    (code_a[c]),
         .outside (outside[c])
      );

      clip_stretch #(
         .HOLD_CYC (HOLD_CYC)
      ) u_str (
         .clk  (clk),
         .rst  (rst),
         .clr  (shdn),
         .trig (outside[c]),
         .busy (busy[c])
      );

      always_comb flag_n[c] = ~(busy[c] & ~shdn);
   end

   assign clip0_n = flag_n[0];
   assign clip1_n = flag_n[1];
endmodule

// File: rtl/clip_flag_gen_chk.sv
module clip_flag_gen_chk #(
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned CLK_KHZ = 200000,
   parameter int unsigned HOLD_NS = 1000,
   parameter int unsigned LO_PCT  = 10,
   parameter int unsigned HI_PCT  = 90
) (
   input logic              clk,
   input logic              rst,
   input logic [CODE_W-1:0] ch0_code,
   input logic [CODE_W-1:0] ch1_code,
   input logic              shdn,
   input logic              clip0_n,
   input logic              clip1_n
);
   import clip_pkg::*;
   localparam int unsigned HOLD_CYC = int'((64'(CLK_KHZ) * 64'(HOLD_NS)) / 64'd1000000);
   localparam int unsigned LW = $clog2(HOLD_CYC + 2);
   localparam logic [CODE_W-1:0] LO_C = CODE_W'(scale_limit(CODE_W, LO_PCT));
   localparam logic [CODE_W-1:0] HI_C = CODE_W'(scale_limit(CODE_W, HI_PCT));

   logic oow0, oow1;
   logic [LW-1:0] low0_q, low1_q;
   always_comb begin
      oow0 = (ch0_code < LO_C) || (ch0_code > HI_C);
      oow1 = (ch1_code < LO_C) || (ch1_code > HI_C);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         low0_q <= '0;
         low1_q <= '0;
      end else begin
         low0_q <= clip0_n ? '0 : ((low0_q == LW'(HOLD_CYC + 1)) ? low0_q : low0_q + 1'b1);
         low1_q <= clip1_n ? '0 : ((low1_q == LW'(HOLD_CYC + 1)) ? low1_q : low1_q + 1'b1);
      end
   end

   // R7
   shdn_masks_flags_chk: assert property (@(posedge clk) disable iff (rst)
      shdn |-> (clip0_n && clip1_n));
   // R3
   trig0_raises_chk: assert property (@(posedge clk) disable iff (rst)
      (oow0 && !shdn) |=> (shdn || !clip0_n));
   // R3
   trig1_raises_chk: assert property (@(posedge clk) disable iff (rst)
      (oow1 && !shdn) |=> (shdn || !clip1_n));
   // R6
   fall0_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
      (!shdn && !clip0_n && $past(clip0_n) && !$past(rst)) |-> $past(oow0));
   // R6
   fall1_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
      (!shdn && !clip1_n && $past(clip1_n) && !$past(rst)) |-> $past(oow1));
   // R4
   min_width0_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(clip0_n) && !shdn) |-> (low0_q >= LW'(HOLD_CYC)));
   // R4
   min_width1_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(clip1_n) && !shdn) |-> (low1_q >= LW'(HOLD_CYC)));
endmodule

bind clip_flag_gen clip_flag_gen_chk #(
   .CODE_W (CODE_W), .CLK_KHZ (CLK_KHZ), .HOLD_NS (HOLD_NS),
   .LO_PCT (LO_PCT), .HI_PCT (HI_PCT)
) u_chk (
   .clk (clk), .rst (rst), .ch0_code (ch0_code), .ch1_code (ch1_code),
   .shdn (shdn), .clip0_n (clip0_n), .clip1_n (clip1_n)
);

// File: tb/clip_flag_gen_bench.sv
`timescale 1ns/1ps
module clip_flag_gen_bench;
   localparam int W    = 12;
   localparam int HOLD = 12;           // 200 MHz * 60 ns
   localparam int LO   = 4095 * 10 / 100;  // R1: 409
   localparam int HI   = 4095 * 90 / 100;  // R2: 3685
   localparam int MID  = 2048;

   logic clk = 0, rst = 1, shdn = 0;
   logic [W-1:0] c0 = MID, c1 = MID;
   logic clip0_n, clip1_n;
   int tests = 0, fails = 0;
   int rem0 = 0, rem1 = 0;
   string tag = "R8";

   always #2.5 clk = ~clk;

   clip_flag_gen #(.CODE_W(W), .CLK_KHZ(200000), .HOLD_NS(60)) u_clip_flag_gen (
      .clk(clk), .rst(rst), .ch0_code(c0), .ch1_code(c1), .shdn(shdn),
      .clip0_n(clip0_n), .clip1_n(clip1_n));

   function automatic bit oow(input int v);
      return (v < LO) || (v > HI);
   endfunction

   always @(posedge clk) begin
      if (rst || shdn) begin
         rem0 = 0; rem1 = 0;
      end else begin
         rem0 = oow(int'(c0)) ? HOLD : (rem0 > 0 ? rem0 - 1 : 0);
         rem1 = oow(int'(c1)) ? HOLD : (rem1 > 0 ? rem1 - 1 : 0);
      end
   end

   always @(negedge clk) begin
      logic e0, e1;
      e0 = !((rem0 > 0) && !shdn);
      e1 = !((rem1 > 0) && !shdn);
      tests += 2;
      if (clip0_n !== e0) begin
         fails++;
         $display("FAIL %s ch0 t=%0t actual=%b expected=%b", tag, $time, clip0_n, e0);
      end
      if (clip1_n !== e1) begin
         fails++;
         $display("FAIL %s ch1 t=%0t actual=%b expected=%b", tag, $time, clip1_n, e1);
      end
   end

   task automatic drive(input int a, input int b, input logic sd, input int n);
      @(posedge clk); #1;
      c0 = W'(a); c1 = W'(b); shdn = sd;
      for (int i = 1; i < n; i++) @(posedge clk);
   endtask

   initial begin
      tag = "R8";
      drive(0, 4095, 0, 4);          // codes ignored during reset
      @(posedge clk); #1 rst = 0;
      drive(MID, MID, 0, 3);
      tag = "R1";
      drive(LO, MID, 0, 3);          // on limit: no flag
      drive(LO - 1, MID, 0, 1);      // one below: flag
      tag = "R4";
      drive(MID, MID, 0, HOLD + 4);
      tag = "R2";
      drive(MID, HI, 0, 3);
      drive(MID, HI + 1, 0, 1);
      tag = "R4";
      drive(MID, MID, 0, HOLD + 4);
      tag = "R5";
      drive(0, MID, 0, 1);
      drive(MID, MID, 0, 5);
      drive(4095, MID, 0, 2);
      drive(MID, MID, 0, HOLD + 4);
      tag = "R6";
      drive(4095, MID, 0, 3);
      drive(MID, 0, 0, 6);
      drive(MID, MID, 0, HOLD + 4);
      tag = "R7";
      drive(0, 4095, 0, 1);
      drive(MID, MID, 0, 3);
      drive(0, 4095, 1, 4);          // shutdown mid-hold, codes ignored
      drive(MID, MID, 0, HOLD + 2);  // no flag after release
      drive(MID, 0, 0, 1);
      drive(MID, 0, 1, 2);
      drive(MID, MID, 0, 4);
      tag = "R3";
      drive(LO - 1, HI + 1, 0, 1);
      drive(MID, MID, 0, HOLD + 3);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule